// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block keeps the 7-bit position of a potentiometer wiper. It drives the tap-select enables of a 128-tap resistor ladder. After reset the wiper sits at mid-scale. The first valid word from non-volatile storage then replaces that value. After that, the position changes only through a small parallel register write port.

A shutdown request can come from an active-low pin or from a bit in a control register. While either is active, the controller disconnects both ends of the ladder, ties the wiper to ground and removes every tap enable. The stored position is kept, so leaving shutdown brings back the tap that was selected before.

A tap change is make-before-break. The new tap's enable rises while the old one is still on. The old enable is dropped one clock later.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: On a clock edge with `rst_n` low, the wiper position becomes 64, the shutdown bit clears and the reload flag clears. Once reset is released, only tap enable 64 is asserted.
- R2: The first `nv_valid` pulse after reset loads `nv_data` into the wiper position on that clock edge.
- R3: Any `nv_valid` pulse after the first one since reset leaves the wiper position unchanged.
- R4: If a wiper write and the first `nv_valid` fall on the same edge, the write value is stored. That strobe still counts as the one reload, so a later strobe has no effect.
- R5: A write with `wr_addr` = 0 loads `wr_data[6:0]` into the wiper position on the next edge, including during shutdown. Writes to addresses 2 and 3 change neither the position nor the shutdown state.
- R6: When the controller is not shut down and no tap change is under way, exactly one tap enable is high. Its index equals the wiper position, so bit 0 is the tap nearest ground and bit 127 the tap nearest the supply. The enable follows a position change one clock later.
- R7: On a tap change, the enables of both the old and the new tap are high for exactly one clock cycle. After that, only the new tap stays on.
- R8: A write with `wr_addr` = 1 stores `wr_data[7]` as the shutdown bit. Effective shutdown is `!shdn_n` OR that bit.
- R9: During effective shutdown, all tap enables are low, `ladder_connect` is 0 and `wiper_gnd` is 1. The pin acts without a clock. The register bit acts from the edge that stores it.
- R10: When shutdown ends, the tap enable at the stored wiper position comes back. This includes a position written during shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 = wiper, 1 = control |
| wr_data | input | 8 | Write data: [6:0] wiper position, [7] shutdown bit |
| nv_valid | input | 1 | Strobe: non-volatile initial value is valid |
| nv_data | input | 7 | Stored initial wiper position |
| shdn_n | input | 1 | Shutdown pin, active low |
| tap_en | output | 128 | Tap switch enables, bit i closes tap i |
| ladder_connect | output | 1 | 1 = ladder ends connected to the supply rails |
| wiper_gnd | output | 1 | 1 = wiper tied to ground |
| wiper_pos | output | 7 | Current wiper register value |

## Verification
The assertions are checked on every cycle. They cover these properties:
- No more than two tap enables are ever high.
- Steady-state enables are one-hot.
- A position change always opens a single overlap cycle that then closes.
- Shutdown clears every enable and switches the ladder outputs.
- A reload after the first one never moves the wiper.

Only the bench scenarios can show the following:
- Every one of the 128 positions maps to its own enable bit.
- A write and the first strobe on the same edge resolve in favour of the write.
- A position written during shutdown is the one restored on exit.
- Unused addresses leave no trace.

// File: rtl/dpot_pkg.sv
// Package: shared constants and register select codes for the wiper controller.
// Assumes a two-bit register address space; codes not listed are unused.
package dpot_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_WIPER = 2'd0,
        SEL_CTRL  = 2'd1
    } reg_sel_e;
endpackage

// File: rtl/dpot_regs.sv
// Module: register bank. Holds the wiper position and the shutdown bit, and
// applies the one-time reload from non-volatile storage.
// Assumes DATA_W = WIPER_W + 1. The top bit of the write word is the
// shutdown bit; the low bits are the position.
module dpot_regs #(
    parameter int WIPER_W   = 7,
    parameter int RESET_POS = 64,
    parameter int DATA_W    = WIPER_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [dpot_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      nv_valid,
    input  logic [WIPER_W-1:0]        nv_data,
    output logic [WIPER_W-1:0]        wiper_q,
    output logic                      ctrl_shdn_q
);
    import dpot_pkg::*;

    localparam logic [WIPER_W-1:0] RST_VAL = WIPER_W'(RESET_POS);
    localparam int                 SD_BIT  = DATA_W - 1;

    logic wr_wiper;
    logic wr_ctrl;
    logic reloaded_q;

    // Decode the write port into one strobe per register.
    always_comb begin
        wr_wiper = wr_en && (wr_addr == SEL_WIPER);
        wr_ctrl  = wr_en && (wr_addr == SEL_CTRL);
    end

    // Wiper position: a write has priority over the one-time reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_q <= RST_VAL;
        end else if (wr_wiper) begin
            wiper_q <= wr_data[WIPER_W-1:0];
        end else if (nv_valid && !reloaded_q) begin
            wiper_q <= nv_data;
        end
    end

    // Reload flag: the first strobe after reset uses up the reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reloaded_q <= 1'b0;
        end else if (nv_valid) begin
            reloaded_q <= 1'b1;
        end
    end

    // Shutdown control bit, written through the control address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_shdn_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_shdn_q <= wr_data[SD_BIT];
        end
    end

    // R1
    reset_pos_chk: assert property (@(posedge clk)
        !rst_n |=> (wiper_q == RST_VAL) && !ctrl_shdn_q);

    // R2
    first_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_valid && !reloaded_q && !wr_wiper) |=> (wiper_q == $past(nv_data)));

    // R3
    late_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_valid && reloaded_q && !wr_wiper) |=> $stable(wiper_q));

    // R5
    wiper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_wiper |=> (wiper_q == $past(wr_data[WIPER_W-1:0])));

    // R8
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_shdn_q == $past(wr_data[SD_BIT])));
endmodule

// File: rtl/dpot_tap_seq.sv
// Module: tap sequencer. Follows the wiper position with a one-cycle lag.
// On a change it keeps the previous tap for one extra cycle, so the switches
// make before they break.
// Assumes the target may change on every cycle; each change opens a fresh
// overlap cycle with the tap that was current just before it.
module dpot_tap_seq #(
    parameter int WIPER_W   = 7,
    parameter int RESET_POS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIPER_W-1:0] target,
    output logic [WIPER_W-1:0] cur_q,
    output logic [WIPER_W-1:0] prev_q,
    output logic               overlap_q
);
    localparam logic [WIPER_W-1:0] RST_VAL = WIPER_W'(RESET_POS);

    logic moving;

    // A move is pending whenever the target differs from the closed tap.
    always_comb moving = (target != cur_q);

    // Advance the closed tap and remember the previous one for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= RST_VAL;
            prev_q    <= RST_VAL;
            overlap_q <= 1'b0;
        end else begin
            overlap_q <= moving;
            if (moving) begin
                prev_q <= cur_q;
                cur_q  <= target;
            end
        end
    end

    // R7
    overlap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moving |=> overlap_q && (prev_q == $past(cur_q)) && (cur_q == $past(target)));

    // R7
    overlap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overlap_q && !moving) |=> !overlap_q);
endmodule

// File: rtl/dpot_tap_decode.sv
// Module: tap decoder. Turns the current tap, and the previous tap during an
// overlap cycle, into the per-tap switch enables.
// Assumes TAPS = 2**WIPER_W. A low enable input clears every switch.
module dpot_tap_decode #(
    parameter int WIPER_W = 7,
    parameter int TAPS    = 1 << WIPER_W
) (
    input  logic               enable,
    input  logic [WIPER_W-1:0] cur,
    input  logic [WIPER_W-1:0] prev,
    input  logic               overlap,
    output logic [TAPS-1:0]    taps
);
    // One comparator pair per tap switch.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign taps[i] = enable &&
                         ((cur == WIPER_W'(i)) || (overlap && (prev == WIPER_W'(i))));
    end
endmodule

// File: rtl/dpot_wiper_ctrl.sv
// Module: top of the digital potentiometer wiper controller. Joins the
// register bank, the tap sequencer and the decoder, and forms effective
// shutdown from the pin and the control bit.
// Assumes shdn_n is synchronous to clk or static; it gates the outputs
// combinationally.
module dpot_wiper_ctrl #(
    parameter int WIPER_W   = 7,
    parameter int RESET_POS = 64,
    parameter int TAPS      = 1 << WIPER_W,
    parameter int DATA_W    = WIPER_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [dpot_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        nv_valid,
    input  logic [WIPER_W-1:0]          nv_data,
    input  logic                        shdn_n,
    output logic [TAPS-1:0]             tap_en,
    output logic                        ladder_connect,
    output logic                        wiper_gnd,
    output logic [WIPER_W-1:0]          wiper_pos
);
    logic [WIPER_W-1:0] wiper_q;
    logic               ctrl_shdn_q;
    logic [WIPER_W-1:0] cur_tap;
    logic [WIPER_W-1:0] prev_tap;
    logic               overlap;
    logic               shutdown;

    dpot_regs #(
        .WIPER_W  (WIPER_W),
        .RESET_POS(RESET_POS),
        .DATA_W   (DATA_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .nv_valid   (nv_valid),
        .nv_data    (nv_data),
        .wiper_q    (wiper_q),
        .ctrl_shdn_q(ctrl_shdn_q)
    );

    dpot_tap_seq #(
        .WIPER_W  (WIPER_W),
        .RESET_POS(RESET_POS)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .target   (wiper_q),
        .cur_q    (cur_tap),
        .prev_q   (prev_tap),
        .overlap_q(overlap)
    );

    // Effective shutdown: the pin request OR the register bit.
    always_comb shutdown = !shdn_n || ctrl_shdn_q;

    dpot_tap_decode #(
        .WIPER_W(WIPER_W),
        .TAPS   (TAPS)
    ) i_dec (
        .enable (!shutdown),
        .cur    (cur_tap),
        .prev   (prev_tap),
        .overlap(overlap),
        .taps   (tap_en)
    );

    // Ladder end switches and wiper ground clamp follow shutdown.
    always_comb begin
        ladder_connect = !shutdown;
        wiper_gnd      = shutdown;
        wiper_pos      = wiper_q;
    end

    // R9
    shutdown_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (tap_en == '0) && wiper_gnd && !ladder_connect);

    // R6
    max_two_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_en) <= 2);

    // R6
    steady_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && !overlap) |-> $onehot(tap_en));

    // R7
    overlap_two_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && overlap) |-> ($countones(tap_en) == 2));
endmodule

// File: tb/test_dpot_wiper_ctrl.sv
`timescale 1ns/1ps
module test_dpot_wiper_ctrl;
    localparam int W    = 7;
    localparam int TAPS = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             nv_valid = 1'b0;
    logic [W-1:0]     nv_data = '0;
    logic             shdn_n = 1'b1;
    logic [TAPS-1:0]  tap_en;
    logic             ladder_connect;
    logic             wiper_gnd;
    logic [W-1:0]     wiper_pos;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dpot_wiper_ctrl i_dpot_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .nv_valid(nv_valid), .nv_data(nv_data),
        .shdn_n(shdn_n), .tap_en(tap_en), .ladder_connect(ladder_connect),
        .wiper_gnd(wiper_gnd), .wiper_pos(wiper_pos)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [TAPS-1:0] act, input logic [TAPS-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [TAPS-1:0] taps2(input int a, input int b);
        logic [TAPS-1:0] v = '0;
        v[a] = 1'b1;
        v[b] = 1'b1;
        return v;
    endfunction

    task automatic chk_pos(input string tag, input int exp);
        chk(wiper_pos == W'(exp), tag, TAPS'(wiper_pos), TAPS'(exp));
    endtask

    task automatic chk_taps(input string tag, input logic [TAPS-1:0] exp);
        chk(tap_en == exp, tag, tap_en, exp);
    endtask

    task automatic chk_sd(input string tag, input bit sd);
        chk(ladder_connect == !sd && wiper_gnd == sd, tag,
            TAPS'({ladder_connect, wiper_gnd}), TAPS'({!sd, sd}));
        if (sd) chk_taps(tag, '0);
    endtask

    // Drive one write for a single edge; outputs are sampled after it.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        int prev;
        do_reset();
        // R1 reset state
        chk_pos("R1 reset position", 64);
        chk_taps("R1 reset tap", taps2(64, 64));
        chk_sd("R1 no shutdown after reset", 1'b0);

        // R2 first strobe reloads
        nv_valid = 1'b1; nv_data = 7'd21;
        tick();
        nv_valid = 1'b0;
        chk_pos("R2 reload", 21);
        chk_taps("R6 tap lags one cycle", taps2(64, 64));
        tick();
        chk_taps("R7 overlap after reload", taps2(64, 21));
        tick();
        chk_taps("R7 old tap dropped", taps2(21, 21));

        // R3 later strobe ignored
        nv_valid = 1'b1; nv_data = 7'd99;
        tick();
        nv_valid = 1'b0;
        tick();
        chk_pos("R3 second strobe ignored", 21);
        chk_taps("R3 tap unchanged", taps2(21, 21));

        // R5 R6 R7 sweep every position upward
        prev = 21;
        for (int v = 0; v < TAPS; v++) begin
            wr(2'd0, {1'b0, W'(v)});
            chk_pos("R5 wiper write", v);
            tick();
            chk_taps("R7 sweep overlap", taps2(prev, v));
            tick();
            chk_taps("R6 sweep steady tap", taps2(v, v));
            prev = v;
        end
        // R7 full-scale jump downward
        wr(2'd0, 8'd0);
        tick();
        chk_taps("R7 jump 127 to 0", taps2(127, 0));
        tick();
        chk_taps("R6 bottom tap", taps2(0, 0));

        // R9 R5 R10 pin shutdown with a write inside it
        shdn_n = 1'b0;
        #1;
        chk_sd("R9 pin shutdown", 1'b1);
        wr(2'd0, 8'd10);
        chk_pos("R5 write during shutdown", 10);
        tick();
        chk_sd("R9 shutdown holds during move", 1'b1);
        tick();
        shdn_n = 1'b1;
        #1;
        chk_sd("R10 pin released", 1'b0);
        chk_taps("R10 restored tap", taps2(10, 10));

        // R8 R9 register shutdown bit
        wr(2'd1, 8'h80);
        chk_sd("R8 control bit shutdown", 1'b1);
        chk_pos("R10 position held", 10);
        wr(2'd1, 8'h7F);
        chk_sd("R8 low bits do not shut down", 1'b0);
        chk_taps("R10 tap after bit clear", taps2(10, 10));
        // R8 both sources, pin alone remaining
        wr(2'd1, 8'h80);
        shdn_n = 1'b0;
        wr(2'd1, 8'h00);
        chk_sd("R8 pin still holds shutdown", 1'b1);
        shdn_n = 1'b1;
        #1;
        chk_sd("R8 both released", 1'b0);

        // R5 unused addresses have no effect
        wr(2'd2, 8'hB3);
        wr(2'd3, 8'h85);
        tick();
        chk_pos("R5 unused address position", 10);
        chk_sd("R5 unused address shutdown", 1'b0);
        chk_taps("R5 unused address tap", taps2(10, 10));

        // R4 write and first strobe on the same edge
        do_reset();
        chk_pos("R1 second reset", 64);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd5;
        nv_valid = 1'b1; nv_data = 7'd77;
        tick();
        wr_en = 1'b0; nv_valid = 1'b0;
        chk_pos("R4 write wins", 5);
        nv_valid = 1'b1;
        tick();
        nv_valid = 1'b0;
        chk_pos("R4 reload consumed", 5);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule